// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Bus Master

This block drives an open-drain clock/data pair as the only master on a two-wire bus of serial EEPROMs. A host issues one command at a time: read or write, a three-bit device select, and a byte count. The block frames the command with start and stop conditions. It sends the device address byte, built from the fixed memory device code and the select bits, and checks each acknowledge. It then streams data bytes to or from the host through byte-wide handshakes.

A device that is busy with its internal write cycle does not acknowledge its address. The block then ends the transfer with a stop and raises its NACK flag. The host can repeat a zero-length command until the flag stays low, which is acknowledge polling. The host may also abort a command at any time, and the block closes the bus with a stop. The SCL half-period is set in system clock cycles by a divider input.

Top module: `eeprom_bus_master`

## Requirements
- R1: Each accepted command opens with a start condition (SDA falls while SCL is released high) and closes with exactly one stop condition (SDA rises while SCL is high). `done` pulses for exactly one clock cycle when the stop completes.
- R2: The first byte on the bus is {4'b1010, cmd_sel[2:0], rw}, with rw=1 for a read and rw=0 for a write. It is sent MSB first.
- R3: A write sends exactly cmd_len data bytes, MSB first, each taken from `wr_data` in a cycle where `wr_valid` and `wr_ready` are both high. While no byte is offered, SCL is held low.
- R4: SDA changes while SCL is high only for a start or a stop. Every data and acknowledge change happens while SCL is held low.
- R5: A read returns cmd_len bytes on `rd_data`, each marked by a one-cycle `rd_valid`. The master drives SDA low in the ninth clock after every byte but the last, and leaves SDA released in the ninth clock after the last byte.
- R6: If SDA is sampled high in the ninth clock after the address byte or after a written data byte, the block moves no further bytes and issues a stop. It then sets `nack`, which holds until the next accepted command.
- R7: A `cmd_abort` pulse while busy makes the block stop at the next bit boundary, or at once if it is waiting for write data. No further data byte is moved. `done` still pulses and `nack` stays low.
- R8: Each SCL high and low half-period lasts max(half_div, 4) clock cycles, apart from low periods stretched while waiting for write data.
- R9: `busy` rises in the cycle after an accepted `cmd_start` and falls in the cycle `done` pulses. A `cmd_start` while busy is ignored. While idle, both line enables are off.
- R10: A command with cmd_len of zero sends only the address byte, takes its acknowledge and stops. This gives 9 SCL pulses plus the one that precedes the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | SCL half-period in clock cycles (floor 4) |
| cmd_start | input | 1 | Begin a command when idle |
| cmd_read | input | 1 | 1 = read command, 0 = write command |
| cmd_sel | input | 3 | Device select bits of the address byte |
| cmd_len | input | LEN_W | Number of data bytes to move |
| cmd_abort | input | 1 | Terminate the current command with a stop |
| wr_data | input | 8 | Next byte to write |
| wr_valid | input | 1 | wr_data holds a byte |
| wr_ready | output | 1 | Block takes wr_data this cycle if wr_valid |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command end |
| nack | output | 1 | Last command ended on a missing acknowledge |
| scl_oe | output | 1 | Pull SCL low when 1, release when 0 |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The in-line properties watch, on every cycle, that SDA never moves under a high SCL outside the start and stop states and that the idle state leaves both lines released. They also check that `done` lasts one cycle, that a raised `nack` coincides with entry into the stop sequence, that an abort while waiting for data goes straight to the stop, and that the half-period counter stays within its latched limit. The byte contents, the address encoding, the ACK/NACK pattern the master gives on reads, the measured half-period lengths and the count of SCL pulses per command are visible only at the bus. A bench-side EEPROM model captures them across writes, reads, a busy device, a wrong select, a zero-length poll, an abort and a divider below the floor.

// File: rtl/eebm_pkg.sv
package eebm_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_BLO,
        S_BHI,
        S_LOAD,
        S_PLO,
        S_PHI,
        S_PREL
    } bus_st_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_WR,
        K_RD
    } byte_kind_t;

    function automatic logic [7:0] addr_byte(input logic [2:0] sel, input logic rd);
        return {DEV_CODE, sel, rd};
    endfunction

endpackage

// File: rtl/eebm_phase.sv
module eebm_phase #(
    parameter int DIV_W    = 16,
    parameter int MIN_HALF = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mid,
    output logic             last
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0] eff_q;
    logic [DIV_W-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst)
            eff_q <= FLOOR;
        else if (!run)
            eff_q <= (half_div < FLOOR) ? FLOOR : half_div;
    end

    assign last = run && (pc == eff_q - 1'b1);
    assign mid  = run && (pc == (eff_q >> 1));

    always_ff @(posedge clk) begin
        if (rst || !run || last)
            pc <= '0;
        else
            pc <= pc + 1'b1;
    end

    // R8
    pc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (pc < eff_q));

endmodule

// File: rtl/eebm_shifter.sv
module eebm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q,
    output logic         msb
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift)
            q <= {q[W-2:0], sin};
    end

    assign msb = q[W-1];

endmodule

// File: rtl/eeprom_bus_master.sv
module eeprom_bus_master import eebm_pkg::*; #(
    parameter int DIV_W    = 16,
    parameter int LEN_W    = 8,
    parameter int MIN_HALF = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_div,
    input  logic             cmd_start,
    input  logic             cmd_read,
    input  logic [2:0]       cmd_sel,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_abort,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             nack,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int BITS = 8;
    localparam int BC_W = $clog2(BITS + 1);
    localparam logic [BC_W-1:0] ACK_SLOT = BC_W'(BITS);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BITS - 1);

    bus_st_t          st;
    byte_kind_t       kind;
    logic [BC_W-1:0]  bitn;
    logic [LEN_W-1:0] left;
    logic             is_read;
    logic             abort_q;
    logic             scl_oe_q, sda_oe_q;
    logic             nack_q, done_q, rd_valid_q;
    logic [7:0]       rd_data_q;

    logic             ph_run, ph_mid, ph_last;
    logic             sh_load, sh_shift, sh_msb;
    logic [7:0]       sh_din, sh_q;
    logic             tx_drive;

    assign ph_run = (st != S_IDLE) && (st != S_LOAD);

    eebm_phase #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_phase (
        .clk(clk), .rst(rst), .run(ph_run), .half_div(half_div),
        .mid(ph_mid), .last(ph_last)
    );

    assign wr_ready = (st == S_LOAD) && !abort_q;
    assign sh_load  = ((st == S_IDLE) && cmd_start) || (wr_ready && wr_valid);
    assign sh_din   = (st == S_IDLE) ? addr_byte(cmd_sel, cmd_read) : wr_data;
    assign sh_shift = (st == S_BHI) && ph_last && (bitn != ACK_SLOT);

    eebm_shifter #(.W(BITS)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .din(sh_din),
        .shift(sh_shift), .sin(sda_in), .q(sh_q), .msb(sh_msb)
    );

    always_comb begin
        if (bitn == ACK_SLOT)
            tx_drive = (kind == K_RD) && (left != '0);
        else
            tx_drive = (kind == K_RD) ? 1'b0 : ~sh_msb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            kind       <= K_ADDR;
            bitn       <= '0;
            left       <= '0;
            is_read    <= 1'b0;
            abort_q    <= 1'b0;
            scl_oe_q   <= 1'b0;
            sda_oe_q   <= 1'b0;
            nack_q     <= 1'b0;
            done_q     <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            done_q     <= 1'b0;
            rd_valid_q <= 1'b0;
            if (cmd_abort && (st != S_IDLE))
                abort_q <= 1'b1;
            case (st)
                S_IDLE: begin
                    if (cmd_start) begin
                        is_read  <= cmd_read;
                        left     <= cmd_len;
                        kind     <= K_ADDR;
                        bitn     <= '0;
                        abort_q  <= 1'b0;
                        nack_q   <= 1'b0;
                        sda_oe_q <= 1'b1;
                        st       <= S_START;
                    end
                end
                S_START: begin
                    if (ph_last) begin
                        scl_oe_q <= 1'b1;
                        st       <= abort_q ? S_PLO : S_BLO;
                    end
                end
                S_BLO: begin
                    if (ph_mid)
                        sda_oe_q <= tx_drive;
                    if (ph_last) begin
                        scl_oe_q <= 1'b0;
                        st       <= S_BHI;
                    end
                end
                S_BHI: begin
                    if (ph_last) begin
                        scl_oe_q <= 1'b1;
                        if (bitn != ACK_SLOT) begin
                            bitn <= bitn + 1'b1;
                            if ((kind == K_RD) && (bitn == LAST_BIT)) begin
                                rd_valid_q <= 1'b1;
                                rd_data_q  <= {sh_q[6:0], sda_in};
                            end
                            st <= abort_q ? S_PLO : S_BLO;
                        end else begin
                            bitn <= '0;
                            if ((kind != K_RD) && sda_in) begin
                                nack_q <= 1'b1;
                                st     <= S_PLO;
                            end else if (abort_q || (left == '0)) begin
                                st <= S_PLO;
                            end else if (is_read) begin
                                kind <= K_RD;
                                left <= left - 1'b1;
                                st   <= S_BLO;
                            end else begin
                                st <= S_LOAD;
                            end
                        end
                    end
                end
                S_LOAD: begin
                    if (abort_q) begin
                        st <= S_PLO;
                    end else if (wr_valid) begin
                        kind <= K_WR;
                        left <= left - 1'b1;
                        st   <= S_BLO;
                    end
                end
                S_PLO: begin
                    if (ph_mid)
                        sda_oe_q <= 1'b1;
                    if (ph_last) begin
                        scl_oe_q <= 1'b0;
                        st       <= S_PHI;
                    end
                end
                S_PHI: begin
                    if (ph_last) begin
                        sda_oe_q <= 1'b0;
                        st       <= S_PREL;
                    end
                end
                S_PREL: begin
                    if (ph_last) begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy     = (st != S_IDLE);
    assign done     = done_q;
    assign nack     = nack_q;
    assign scl_oe   = scl_oe_q;
    assign sda_oe   = sda_oe_q;
    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R4
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
        |-> ((st == S_START) || (st == S_PREL)));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));

    // R6
    nack_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nack) |-> (st == S_PLO));

    // R7
    abort_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_q && (st == S_LOAD)) |=> (st == S_PLO));

endmodule

// File: tb/tb_eeprom_bus_master.sv
module tb_eeprom_bus_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] half_div = 16'd6;
    logic        cmd_start = 1'b0, cmd_read = 1'b0, cmd_abort = 1'b0;
    logic [2:0]  cmd_sel = 3'd0;
    logic [7:0]  cmd_len = 8'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        wr_valid = 1'b0;
    logic        wr_ready, rd_valid, busy, done, nack, scl_oe, sda_oe;
    logic [7:0]  rd_data;
    logic        s_drv = 1'b0;
    logic        scl, sda;

    always #2 clk = ~clk;

    assign scl = ~scl_oe;
    assign sda = ~(sda_oe | s_drv);

    eeprom_bus_master dut (
        .clk(clk), .rst(rst), .half_div(half_div),
        .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_sel(cmd_sel),
        .cmd_len(cmd_len), .cmd_abort(cmd_abort),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .nack(nack),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
    );

    int total = 0, bad = 0;
    logic [7:0] exp_wr[$];
    logic [7:0] exp_rd[$];
    logic [7:0] host_wr[$];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // host write-data feeder: a handshake seen at one falling edge lands at the next rising edge
    logic pend = 1'b0;
    always @(negedge clk) begin
        if (pend && host_wr.size() > 0) void'(host_wr.pop_front());
        wr_valid = (host_wr.size() > 0);
        wr_data  = (host_wr.size() > 0) ? host_wr[0] : 8'h00;
        pend     = wr_valid && wr_ready;
    end

    // read scoreboard
    int rd_seen = 0;
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            rd_seen++;
            if (exp_rd.size() == 0) chk("R5 unexpected read byte", rd_data, -1);
            else chk("R5 read byte", rd_data, exp_rd.pop_front());
        end
    end

    // EEPROM model on the bus
    localparam logic [2:0] SLV_SEL = 3'b101;
    logic       pscl = 1'b1, psda = 1'b1;
    int         n_start = 0, n_stop = 0, m_acks = 0, m_nacks = 0, wr_rx = 0;
    logic [7:0] last_addr = 8'h00, sh = 8'h00, tx = 8'h00;
    int         bitcnt = 0, mode = 0;
    logic       ackslot = 1'b0, active = 1'b0, m_ack_now = 1'b0, slave_busy = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            active = 1'b0;
            s_drv <= 1'b0;
        end else if (scl && pscl && psda && !sda) begin
            n_start++; active = 1'b1; bitcnt = 0; ackslot = 1'b0; mode = 0;
            s_drv <= 1'b0;
        end else if (scl && pscl && !psda && sda) begin
            n_stop++; active = 1'b0;
            s_drv <= 1'b0;
        end else if (active && scl && !pscl) begin
            if (bitcnt < 8) begin
                sh = {sh[6:0], sda}; bitcnt++;
            end else if (ackslot && mode == 2) begin
                m_ack_now = !sda;
                if (!sda) m_acks++; else m_nacks++;
            end
        end else if (active && !scl && pscl) begin
            if (bitcnt == 8 && !ackslot) begin
                ackslot = 1'b1;
                if (mode == 0) begin
                    last_addr = sh;
                    if (sh[7:1] == {4'b1010, SLV_SEL} && !slave_busy) s_drv <= 1'b1;
                    else active = 1'b0;
                end else if (mode == 1) begin
                    wr_rx++;
                    if (exp_wr.size() == 0) chk("R3 unexpected write byte", sh, -1);
                    else chk("R3 write byte", sh, exp_wr.pop_front());
                    s_drv <= 1'b1;
                end else begin
                    s_drv <= 1'b0;
                end
            end else if (ackslot) begin
                ackslot = 1'b0; bitcnt = 0;
                if (mode == 0) begin
                    mode = last_addr[0] ? 2 : 1;
                    if (mode == 2) begin tx = 8'h5A; s_drv <= ~tx[7]; end
                    else s_drv <= 1'b0;
                end else if (mode == 1) begin
                    s_drv <= 1'b0;
                end else if (m_ack_now) begin
                    tx = tx + 8'h37; s_drv <= ~tx[7];
                end else begin
                    s_drv <= 1'b0; active = 1'b0;
                end
            end else if (mode == 2 && bitcnt < 8) begin
                s_drv <= ~tx[7 - bitcnt];
            end
        end
        pscl = scl;
        psda = sda;
    end

    // SCL timing monitor
    logic mscl = 1'b1, saw_rise = 1'b0, saw_fall = 1'b0;
    int   run_len = 0, hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0, rises = 0;
    always @(negedge clk) begin
        if (!busy) begin
            saw_rise = 1'b0; saw_fall = 1'b0; run_len = 1;
        end else if (scl == mscl) begin
            run_len++;
        end else begin
            if (mscl && saw_rise) begin
                if (run_len < hi_min) hi_min = run_len;
                if (run_len > hi_max) hi_max = run_len;
            end
            if (!mscl && saw_fall) begin
                if (run_len < lo_min) lo_min = run_len;
                if (run_len > lo_max) lo_max = run_len;
            end
            if (scl) begin saw_rise = 1'b1; rises++; end
            else saw_fall = 1'b1;
            run_len = 1;
        end
        mscl = scl;
    end

    task automatic clear_meas();
        hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0; rises = 0;
    endtask

    task automatic start_cmd(input logic rd, input logic [2:0] sel, input int len);
        @(negedge clk);
        cmd_read = rd; cmd_sel = sel; cmd_len = 8'(len); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk("R1 done seen", int'(done), 1);
        chk("R9 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk("R1 done single cycle", int'(done), 0);
    endtask

    int s0, p0, w0, r0, a0, na0;
    task automatic snap();
        s0 = n_start; p0 = n_stop; w0 = wr_rx; r0 = rd_seen; a0 = m_acks; na0 = m_nacks;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset scl_oe", int'(scl_oe), 0);
        chk("R9 reset sda_oe", int'(sda_oe), 0);
        chk("R6 reset nack", int'(nack), 0);
        chk("R1 reset done", int'(done), 0);

        // write three bytes, with a second start ignored while busy
        snap(); clear_meas();
        host_wr.push_back(8'hC3); host_wr.push_back(8'h5E); host_wr.push_back(8'h81);
        exp_wr.push_back(8'hC3);  exp_wr.push_back(8'h5E);  exp_wr.push_back(8'h81);
        start_cmd(1'b0, 3'b101, 3);
        chk("R9 busy after start", int'(busy), 1);
        repeat (40) @(negedge clk);
        cmd_read = 1'b1; cmd_sel = 3'b010; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        chk("R1 one start", n_start - s0, 1);
        chk("R1 one stop", n_stop - p0, 1);
        chk("R2 write address byte", last_addr, 8'hAA);
        chk("R3 bytes written", wr_rx - w0, 3);
        chk("R3 scoreboard drained", exp_wr.size(), 0);
        chk("R3 clock count", rises, 37);
        chk("R6 nack low on ack", int'(nack), 0);
        chk("R8 high min", hi_min, 6);
        chk("R8 high max", hi_max, 6);
        repeat (3) @(negedge clk);
        chk("R9 ignored start left idle", int'(busy), 0);

        // read four bytes
        snap(); clear_meas();
        exp_rd.push_back(8'h5A); exp_rd.push_back(8'h91);
        exp_rd.push_back(8'hC8); exp_rd.push_back(8'hFF);
        start_cmd(1'b1, 3'b101, 4);
        wait_done();
        chk("R2 read address byte", last_addr, 8'hAB);
        chk("R5 bytes read", rd_seen - r0, 4);
        chk("R5 master acks", m_acks - a0, 3);
        chk("R5 master final nack", m_nacks - na0, 1);
        chk("R5 scoreboard drained", exp_rd.size(), 0);
        chk("R8 low min", lo_min, 6);
        chk("R8 low max", lo_max, 6);
        chk("R1 read stop", n_stop - p0, 1);

        // busy device refuses its address
        slave_busy = 1'b1;
        snap(); clear_meas();
        start_cmd(1'b0, 3'b101, 2);
        wait_done();
        chk("R6 nack on busy device", int'(nack), 1);
        chk("R6 no data after nack", wr_rx - w0, 0);
        chk("R6 stop after nack", n_stop - p0, 1);
        chk("R6 clocks after nack", rises, 10);
        repeat (5) @(negedge clk);
        chk("R6 nack held", int'(nack), 1);

        // zero-length poll once the device is ready
        slave_busy = 1'b0;
        snap(); clear_meas();
        start_cmd(1'b0, 3'b101, 0);
        wait_done();
        chk("R10 poll nack clear", int'(nack), 0);
        chk("R10 poll clocks", rises, 10);
        chk("R10 poll start", n_start - s0, 1);
        chk("R10 poll stop", n_stop - p0, 1);

        // wrong select on a read
        snap(); clear_meas();
        start_cmd(1'b1, 3'b011, 2);
        wait_done();
        chk("R6 nack on wrong select", int'(nack), 1);
        chk("R6 no read after nack", rd_seen - r0, 0);
        chk("R2 wrong select address", last_addr, 8'hA7);

        // abort while waiting for the second write byte
        snap(); clear_meas();
        host_wr.push_back(8'h6E); exp_wr.push_back(8'h6E);
        start_cmd(1'b0, 3'b101, 3);
        begin
            int n = 0;
            while (!(wr_ready && host_wr.size() == 0) && n < 5000) begin @(negedge clk); n++; end
        end
        cmd_abort = 1'b1;
        @(negedge clk);
        cmd_abort = 1'b0;
        wait_done();
        chk("R7 bytes before abort", wr_rx - w0, 1);
        chk("R7 abort stop", n_stop - p0, 1);
        chk("R7 abort clocks", rises, 19);
        chk("R7 abort nack low", int'(nack), 0);

        // divider below the floor
        half_div = 16'd2;
        snap(); clear_meas();
        start_cmd(1'b0, 3'b101, 0);
        wait_done();
        chk("R8 floor high min", hi_min, 4);
        chk("R8 floor high max", hi_max, 4);
        chk("R8 floor low max", lo_max, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule